// File: doc/BRIEF.md
# Dual Comparator Fault Latch

This block turns the results of two threshold comparators into a latched fault indication and an active-low fault output. Each comparator result arrives as a single bit that is high when the monitored voltage is above a shared reference. A per-channel polarity bit decides whether the channel flags an under-voltage (input below reference) or an over-voltage (input above reference) condition. A per-channel enable bit decides whether that channel may trip the fault output.

The comparator bits are resynchronised, qualified by polarity and enable, and watched for rising edges. A new fault edge on any enabled channel sets a fault latch. The latch drives the fault output low and freezes a snapshot of both channels' live fault state. Software can clear the latch at any time, even while the fault persists. The latch then stays clear until a fresh fault edge. A simple register port replaces the serial host link: writes take effect on the clock edge and reads are combinational.

Register map (8-bit data, 2-bit address, two channels):

- Address 0, control, read/write: bits [1:0] are polarity per channel and bits [3:2] are enable per channel.
- Address 1, status, read-only: bits [1:0] are live faults, bits [3:2] are the snapshot, and bit 4 is the latch.
- Address 2, command: writing bit 0 = 1 clears the latch.

Top module: `dual_cmp_fault_latch`

## Requirements
- R1: After reset the latch and the snapshot are 0, fault_n is 1, and control reads 0x00. With inputs low and polarity 0, the status live bits read 1 for both channels.
- R2: A change on cmp_above appears in the status live bits after two clock edges, through a two-stage synchroniser.
- R3: Live fault bit i is 1 when polarity bit i is 1 and the synchronised input i is 1 (over-voltage). It is also 1 when polarity bit i is 0 and the synchronised input i is 0 (under-voltage).
- R4: A channel whose enable bit is 0 never sets the latch, and never pulls fault_n low, whatever its live state.
- R5: A 0-to-1 change of (live AND enable) on any channel sets the latch on the following edge. fault_n is 0 exactly while the latch is 1.
- R6: A write of bit 0 = 1 to address 2 clears the latch on that edge, even while the fault persists. A persisting fault does not set the latch again; only a new 0-to-1 qualified edge does.
- R7: When the latch goes from 0 to 1, status bits [3:2] capture both channels' live bits of that cycle. They hold while the latch stays set, and a clear returns them to 0.
- R8: If a clear write and a qualified fault edge fall on the same edge, the latch stays 1 and the snapshot is recaptured.
- R9: Writes to address 1 or address 3, and writes to address 2 with bit 0 = 0, change neither control nor latch nor snapshot.
- R10: Control reads back bits [3:0] as written and bits [7:4] as 0. Status bits [7:5] read 0, and addresses 2 and 3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | 2 | Comparator results, 1 = input above reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| fault_n | output | 1 | Active-low fault output (open-drain style: 0 = pull low) |

## Verification
A wrong synchroniser depth or polarity decode shows in the status live bits within two or three cycles of an input change. A broken edge detector or enable qualification shows on fault_n one cycle after the qualified edge. It appears either as a missed trip or as a retrigger after a clear while the fault persists. Snapshot or set-versus-clear priority faults show in status bits [4:2] on the very edge where the clear and the fault edge meet. The reference model compares fault_n and the addressed register on every clock, so each such divergence is caught on the first cycle it reaches a port.

// File: rtl/dcfl_pkg.sv
package dcfl_pkg;
   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_STAT = 1;
   localparam int unsigned ADDR_CMD  = 2;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dcfl_sync.sv
module dcfl_sync #(
   parameter int unsigned W       = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("dcfl_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("dcfl_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stg[i] <= {W{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfl_chan_qual.sv
module dcfl_chan_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic above_s,
   input  logic pol_ov,
   input  logic en,
   output logic live,
   output logic rise
);
   logic qual;
   logic qual_d;

   // polarity: 1 = over-voltage (fault when above), 0 = under-voltage
   always_comb begin
      live = pol_ov ? above_s : ~above_s;
      qual = live & en;
      rise = qual & ~qual_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qual_d <= 1'b0;
      else        qual_d <= qual;
   end

   AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R5
endmodule

// File: rtl/dcfl_latch.sv
module dcfl_latch #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] rise,
   input  logic [NUM_CH-1:0] live,
   input  logic              clr,
   output logic              latched,
   output logic [NUM_CH-1:0] snap
);
   logic any_rise;
   assign any_rise = |rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
         snap    <= '0;
      end else if (any_rise) begin
         latched <= 1'b1;
         if (!latched || clr) snap <= live;
      end else if (clr) begin
         latched <= 1'b0;
         snap    <= '0;
      end
   end

   AST_EDGE_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      any_rise |=> latched); // R5
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!latched && !any_rise) |=> !latched); // R6
   AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !any_rise) |=> (!latched && snap == '0)); // R6
   AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr) |=> $stable(snap)); // R7
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && any_rise) |=> (latched && snap == $past(live))); // R8
endmodule

// File: rtl/dcfl_regs.sv
module dcfl_regs
   import dcfl_pkg::*;
#(
   parameter int unsigned           NUM_CH  = 2,
   parameter int unsigned           DATA_W  = 8,
   parameter int unsigned           ADDR_W  = 2,
   parameter logic [NUM_CH-1:0]     RST_POL = '0,
   parameter logic [NUM_CH-1:0]     RST_EN  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NUM_CH-1:0] live,
   input  logic [NUM_CH-1:0] snap,
   input  logic              latched,
   output logic [NUM_CH-1:0] pol,
   output logic [NUM_CH-1:0] en,
   output logic              clr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned LAT_BIT = 2 * NUM_CH;

   initial begin
      assert (DATA_W >= LAT_BIT + 1) else $error("dcfl_regs: DATA_W too small for status layout");
      assert (ADDR_W >= 2) else $error("dcfl_regs: ADDR_W must be at least 2");
   end

   reg_sel_e wsel, rsel;
   logic     unused_wr;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      if (a == ADDR_W'(ADDR_CTRL))      return SEL_CTRL;
      else if (a == ADDR_W'(ADDR_STAT)) return SEL_STAT;
      else if (a == ADDR_W'(ADDR_CMD))  return SEL_CMD;
      else                              return SEL_NONE;
   endfunction

   always_comb begin
      wsel = decode(wr_addr);
      rsel = decode(rd_addr);
   end

   assign unused_wr = ^wr_data;
   assign clr       = wr_en && (wsel == SEL_CMD) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol <= RST_POL;
         en  <= RST_EN;
      end else if (wr_en && wsel == SEL_CTRL) begin
         pol <= wr_data[NUM_CH-1:0];
         en  <= wr_data[2*NUM_CH-1:NUM_CH];
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rsel)
         SEL_CTRL: begin
            rd_data[NUM_CH-1:0]        = pol;
            rd_data[2*NUM_CH-1:NUM_CH] = en;
         end
         SEL_STAT: begin
            rd_data[NUM_CH-1:0]        = live;
            rd_data[2*NUM_CH-1:NUM_CH] = snap;
            rd_data[LAT_BIT]           = latched;
         end
         default: rd_data = '0;
      endcase
   end

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel != SEL_CTRL) |=> ($stable(pol) && $stable(en))); // R9
endmodule

// File: rtl/dual_cmp_fault_latch.sv
module dual_cmp_fault_latch #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cmp_above,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              fault_n
);
   initial begin
      assert (NUM_CH >= 1) else $error("dual_cmp_fault_latch: NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] above_s, pol, en, live, rise, snap;
   logic              clr, latched;

   dcfl_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_above), .q(above_s)
   );

   for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
      dcfl_chan_qual u_qual (
         .clk(clk), .rst_n(rst_n), .above_s(above_s[i]), .pol_ov(pol[i]),
         .en(en[i]), .live(live[i]), .rise(rise[i])
      );
   end

   dcfl_latch #(.NUM_CH(NUM_CH)) u_latch (
      .clk(clk), .rst_n(rst_n), .rise(rise), .live(live), .clr(clr),
      .latched(latched), .snap(snap)
   );

   dcfl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .live(live), .snap(snap), .latched(latched),
      .pol(pol), .en(en), .clr(clr), .rd_data(rd_data)
   );

   assign fault_n = ~latched;

   AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_n && ((live & en) == '0)) |=> fault_n); // R4
endmodule

// File: tb/dual_cmp_fault_latch_tb.sv
module dual_cmp_fault_latch_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] cmp;
   logic       wr_en;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic [1:0] rd_addr;
   logic [7:0] rd_data;
   logic       fault_n;

   always #10 clk = ~clk;

   dual_cmp_fault_latch u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_above(cmp), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fault_n(fault_n)
   );

   int    total = 0;
   int    bad   = 0;
   string cur_req = "R1";

   bit [1:0] m_s1, m_s2, m_pol, m_en, m_qprev, m_snap;
   bit       m_lat;

   function automatic bit [1:0] m_live();
      bit [1:0] l;
      for (int i = 0; i < 2; i++) l[i] = m_pol[i] ? m_s2[i] : !m_s2[i];
      return l;
   endfunction

   function automatic bit [7:0] m_read(bit [1:0] a);
      case (a)
         2'd0:    return {4'b0, m_en, m_pol};
         2'd1:    return {3'b0, m_lat, m_snap, m_live()};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_step();
      bit [1:0] l, q, r;
      bit       c;
      l = m_live();
      q = l & m_en;
      r = q & ~m_qprev;
      c = wr_en && wr_addr == 2'd2 && wr_data[0];
      if (r != 0) begin
         if (!m_lat || c) m_snap = l;
         m_lat = 1'b1;
      end else if (c) begin
         m_lat  = 1'b0;
         m_snap = 2'b00;
      end
      m_qprev = q;
      if (wr_en && wr_addr == 2'd0) begin
         m_pol = wr_data[1:0];
         m_en  = wr_data[3:2];
      end
      m_s2 = m_s1;
      m_s1 = cmp;
   endtask

   task automatic model_reset();
      m_s1 = 0; m_s2 = 0; m_pol = 0; m_en = 0; m_qprev = 0; m_snap = 0; m_lat = 0;
   endtask

   task automatic check(bit ok, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n) model_step();
      else       model_reset();
      #2;
      check(fault_n === !m_lat, "fault_n", {7'b0, fault_n}, {7'b0, !m_lat});
      check(rd_data === m_read(rd_addr), "rd_data", rd_data, m_read(rd_addr));
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(bit [1:0] a, bit [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
   endtask

   initial begin
      #(20 * 200000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmp = 2'b00; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00; rd_addr = 2'd1;
      model_reset();
      cur_req = "R1";
      ticks(3);
      rst_n = 1'b1;
      tick();
      check(fault_n === 1'b1, "reset fault_n", {7'b0, fault_n}, 8'h01);
      check(rd_data === 8'h03, "reset status", rd_data, 8'h03);
      rd_addr = 2'd0; tick();
      check(rd_data === 8'h00, "reset ctrl", rd_data, 8'h00);

      cur_req = "R10";
      wr(2'd0, 8'h0B); tick();
      check(rd_data === 8'h0B, "ctrl readback", rd_data, 8'h0B);
      wr(2'd0, 8'hF3); tick();
      check(rd_data === 8'h03, "ctrl upper bits", rd_data, 8'h03);
      rd_addr = 2'd2; tick();
      rd_addr = 2'd3; tick();

      cur_req = "R3";
      rd_addr = 2'd1;
      wr(2'd0, 8'h01);
      cmp = 2'b00; ticks(3);
      check(rd_data[1:0] === 2'b10, "live pol mix low", rd_data, 8'h02);
      cmp = 2'b11; ticks(3);
      check(rd_data[1:0] === 2'b01, "live pol mix high", rd_data, 8'h01);

      cur_req = "R2";
      cmp = 2'b10; tick(); tick();
      cmp = 2'b01; tick(); tick(); tick();
      cmp = 2'b00; ticks(3);

      cur_req = "R4";
      for (int i = 0; i < 6; i++) begin cmp = 2'(i); tick(); end
      check(fault_n === 1'b1, "disabled channels", {7'b0, fault_n}, 8'h01);

      cur_req = "R5";
      cmp = 2'b00; ticks(3);
      wr(2'd0, 8'h05); ticks(2);
      cmp = 2'b01; ticks(4);
      check(fault_n === 1'b0, "trip on ch0 edge", {7'b0, fault_n}, 8'h00);

      cur_req = "R7";
      check(rd_data[4:2] === 3'b111, "snapshot both live", rd_data, 8'h1F);
      cmp = 2'b11; ticks(4);

      cur_req = "R6";
      wr(2'd2, 8'h01);
      check(fault_n === 1'b1, "clear while faulted", {7'b0, fault_n}, 8'h01);
      ticks(5);
      cmp = 2'b10; ticks(3);
      cmp = 2'b11; ticks(4);
      check(fault_n === 1'b0, "retrigger on new edge", {7'b0, fault_n}, 8'h00);

      cur_req = "R8";
      wr(2'd2, 8'h01);
      cmp = 2'b10; ticks(4);
      cmp = 2'b11; tick(); tick();
      wr(2'd2, 8'h01);
      check(fault_n === 1'b0, "set beats clear", {7'b0, fault_n}, 8'h00);
      ticks(2);

      cur_req = "R9";
      wr(2'd1, 8'hFF); wr(2'd3, 8'hFF); wr(2'd2, 8'hFE);
      check(fault_n === 1'b0, "ignored writes keep latch", {7'b0, fault_n}, 8'h00);
      rd_addr = 2'd0; tick();
      check(rd_data === 8'h05, "ignored writes keep ctrl", rd_data, 8'h05);

      cur_req = "R5/R6/R7/R8 random";
      for (int i = 0; i < 3000; i++) begin
         cmp     = 2'($urandom);
         rd_addr = 2'($urandom);
         if (($urandom % 16) == 0)      wr(2'($urandom), 8'($urandom));
         else if (($urandom % 8) == 0)  wr(2'd2, 8'h01);
         else                           tick();
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule